// File: doc/BRIEF.md
# Millisecond Interval Timer

This block is a periodic interrupt source whose period is a whole number of milliseconds. A 9-bit period field sets the period: with a field value of N, the interrupt output goes high every N+1 milliseconds. The time base comes from the block's own clock. A parameter gives the clock frequency in hertz, and a prescaler divides it down to one-millisecond strokes.

Software reaches the block through a simple 32-bit register port, which offers two word locations. A write to the period location stores a new period and starts timing again from zero. A read of the count location returns zero, and as a side effect it takes the interrupt down. Once the interrupt is raised it stays high until it is acknowledged by that read or until the period is written again. The timer reloads itself at every expiry, so it keeps running without further software action.

Top module: `ms_interval_timer`

## Requirements
- R1: A write at byte offset 0x228 (address bits [ADDR_W-1:2] matching 0x228>>2) stores bits [8:0] of the write data as the period field and discards bits [31:9]. Writes to any other offset leave the period and the timing unchanged.
- R2: A write to the period location clears the interrupt on the next clock edge and restarts timing. The first rise after the write comes exactly (N+1)*D clock edges after the edge that took the write, where D = CLK_HZ/1000.
- R3: One millisecond is D clock cycles, and the period is N+1 milliseconds. A field of 0 gives a period of D cycles, and a field of 511 gives 512*D cycles.
- R4: At every expiry the next period starts with no gap, so successive rises are (N+1)*D cycles apart while the interrupt is acknowledged in between.
- R5: A read at byte offset 0x230 returns 0 on bus_rdata and lowers the interrupt at the next clock edge.
- R6: When an expiry and an acknowledge read occur in the same cycle, the expiry wins and the interrupt stays high.
- R7: Reset sets the period field to 0 and the interrupt low, and reset holds the prescaler in place. The first rise comes D edges after the last edge with reset high.
- R8: The interrupt stays high until it is acknowledged or the period is written. Reads at other offsets do not clear it, and every read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, CLK_HZ hertz |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, always zero |
| irq_o | output | 1 | Level interrupt, high while an expiry is unacknowledged |

## Verification
The embedded properties check the following on every cycle: the priority order between a period write, an expiry and an acknowledge; that the interrupt holds its level when none of these occurs; that the stored period changes only on a write to its own location; and that both counters stay within their bounds. Properties cannot show the absolute time of each rise, measured from a write or from reset, for short, long and masked period values. The bench shows this with scenarios, using a queue of expected rise cycles. The same applies to the timing staying undisturbed by writes to other offsets, and to the collision between an expiry and an acknowledge read.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

    localparam int unsigned DATA_W     = 32;
    localparam int unsigned PERIOD_W   = 9;
    localparam int unsigned OFS_PERIOD = 'h228;
    localparam int unsigned OFS_COUNT  = 'h230;

    typedef logic [PERIOD_W-1:0] period_t;

    typedef struct packed {
        logic    period_wr;
        logic    ack;
        period_t new_period;
    } bus_cmd_t;

    // cycles per millisecond, never below one
    function automatic int unsigned ms_divider(input int unsigned clk_hz);
        int unsigned d;
        d = clk_hz / 1000;
        return (d < 1) ? 1 : d;
    endfunction

    // true when a word index selects the given byte offset
    function automatic logic word_hit(input int unsigned word_idx,
                                      input int unsigned byte_ofs);
        return word_idx == (byte_ofs >> 2);
    endfunction

endpackage

// File: rtl/itmr_prescaler.sv
module itmr_prescaler #(
    parameter int unsigned DIV = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_pass
            logic unused_pass;
            assign unused_pass = ^{clk, rst, restart};
            assign tick = 1'b1;
        end else begin : g_div
            localparam int unsigned CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk) begin
                if (rst || restart) begin
                    cnt_q <= '0;
                end else if (cnt_q == LAST) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign tick = (cnt_q == LAST);

            AST_PRESC_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
                cnt_q <= LAST); // R3
            AST_PRESC_RESTART: assert property (@(posedge clk) disable iff (rst)
                restart |=> !tick); // R2
        end
    endgenerate
endmodule

// File: rtl/itmr_period_ctr.sv
module itmr_period_ctr
    import itmr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    restart,
    input  logic    tick,
    input  period_t limit,
    output logic    expire
);
    period_t ms_q;

    assign expire = tick && (ms_q == limit);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            ms_q <= '0;
        end else if (tick) begin
            ms_q <= expire ? '0 : ms_q + 1'b1;
        end
    end

    AST_MS_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (rst)
        ms_q <= limit); // R3
    AST_MS_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        (restart || expire) |=> (ms_q == '0)); // R4
endmodule

// File: rtl/itmr_regif.sv
module itmr_regif
    import itmr_pkg::*;
#(
    parameter int unsigned ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              expire,
    output logic              restart,
    output period_t           period,
    output logic              irq
);
    bus_cmd_t cmd;
    period_t  period_q;
    logic     irq_q;
    logic     unused_bits;

    always_comb begin
        cmd            = '0;
        cmd.period_wr  = bus_wr && word_hit(int'(bus_addr[ADDR_W-1:2]), OFS_PERIOD);
        cmd.ack        = bus_rd && word_hit(int'(bus_addr[ADDR_W-1:2]), OFS_COUNT);
        cmd.new_period = bus_wdata[PERIOD_W-1:0];
    end

    assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:PERIOD_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            period_q <= '0;
        end else if (cmd.period_wr) begin
            period_q <= cmd.new_period;
        end
    end

    // write beats expiry, expiry beats acknowledge
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else if (cmd.period_wr) begin
            irq_q <= 1'b0;
        end else if (expire) begin
            irq_q <= 1'b1;
        end else if (cmd.ack) begin
            irq_q <= 1'b0;
        end
    end

    assign restart   = cmd.period_wr;
    assign period    = period_q;
    assign irq       = irq_q;
    assign bus_rdata = '0;

    AST_PERIOD_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !cmd.period_wr |=> $stable(period_q)); // R1
    AST_WRITE_CLEARS_IRQ: assert property (@(posedge clk) disable iff (rst)
        cmd.period_wr |=> !irq_q); // R2
    AST_EXPIRY_RAISES: assert property (@(posedge clk) disable iff (rst)
        (expire && !cmd.period_wr) |=> irq_q); // R4
    AST_ACK_CLEARS_IRQ: assert property (@(posedge clk) disable iff (rst)
        (cmd.ack && !expire && !cmd.period_wr) |=> !irq_q); // R5
    AST_EXPIRY_BEATS_ACK: assert property (@(posedge clk) disable iff (rst)
        (cmd.ack && expire && !cmd.period_wr) |=> irq_q); // R6
    AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (irq_q && !cmd.ack && !cmd.period_wr) |=> irq_q); // R8
endmodule

// File: rtl/ms_interval_timer.sv
module ms_interval_timer
    import itmr_pkg::*;
#(
    parameter int unsigned CLK_HZ = 250_000_000,
    parameter int unsigned ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    localparam int unsigned TICKS_PER_MS = ms_divider(CLK_HZ);

    logic    restart;
    logic    ms_tick;
    logic    expire;
    period_t period;

    itmr_regif #(.ADDR_W(ADDR_W)) u_regif (
        .clk      (clk),
        .rst      (rst),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .expire   (expire),
        .restart  (restart),
        .period   (period),
        .irq      (irq_o)
    );

    itmr_prescaler #(.DIV(TICKS_PER_MS)) u_presc (
        .clk    (clk),
        .rst    (rst),
        .restart(restart),
        .tick   (ms_tick)
    );

    itmr_period_ctr u_period (
        .clk    (clk),
        .rst    (rst),
        .restart(restart),
        .tick   (ms_tick),
        .limit  (period),
        .expire (expire)
    );

    AST_RDATA_ZERO: assert property (@(posedge clk) disable iff (rst)
        bus_rd |-> (bus_rdata == '0)); // R8
endmodule

// File: tb/ms_interval_timer_tb_top.sv
module ms_interval_timer_tb_top;
    localparam int unsigned CLK_HZ = 8000;
    localparam int unsigned D      = CLK_HZ / 1000;
    localparam int unsigned AW     = 14;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq_o;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int exp_q[$];
    logic irq_prev = 1'b0;
    bit   done = 1'b0;

    ms_interval_timer #(.CLK_HZ(CLK_HZ), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // monitor: every rise must match the head of the expectation queue
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (irq_o && !irq_prev) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 unexpected rise", cyc, -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(cyc == e, "R2/R3/R4 rise cycle", cyc, e);
                end
            end
            irq_prev = irq_o;
        end
    end

    // called just after a negedge; returns the cycle of the driving negedge
    task automatic bus_write(input int ofs, input logic [31:0] data, output int c);
        c = cyc;
        bus_addr  = AW'(ofs);
        bus_wdata = data;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input int ofs, input string req);
        bus_addr = AW'(ofs);
        bus_rd   = 1'b1;
        #1;
        check(bus_rdata == 32'd0, req, int'(bus_rdata), 0);
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic wait_irq();
        while (!irq_o) @(negedge clk);
    endtask

    task automatic ack();
        bus_read('h230, "R5 count reads zero");
        check(irq_o == 1'b0, "R5 ack clears irq", int'(irq_o), 0);
    endtask

    initial begin
        int c;
        int x;
        repeat (3) @(negedge clk);
        check(irq_o == 1'b0, "R7 irq low in reset", int'(irq_o), 0);
        // R7: field 0 after reset, first rise D edges after the last reset edge
        c = cyc;
        exp_q.push_back(c + D);
        rst = 1'b0;
        @(negedge clk);
        wait_irq();
        ack();

        // R2, R3, R4: field 3, three periods with acknowledges
        bus_write('h228, 32'd3, c);
        check(irq_o == 1'b0, "R2 irq low after write", int'(irq_o), 0);
        for (int k = 1; k <= 3; k++) exp_q.push_back(c + 1 + k * 4 * D);
        for (int k = 0; k < 3; k++) begin
            wait_irq();
            ack();
        end

        // R1: upper data bits dropped, field becomes 2; stray writes ignored
        bus_write('h228, 32'hFFFF_FE02, c);
        exp_q.push_back(c + 1 + 3 * D);
        exp_q.push_back(c + 1 + 6 * D);
        bus_write('h230, 32'h0000_01F0, x);
        bus_write('h100, 32'h0000_0001, x);
        bus_write('h22C, 32'h0000_0000, x);
        wait_irq();
        ack();
        wait_irq();

        // R8: irq held; a read elsewhere does not clear it
        bus_read('h228, "R8 other read returns zero");
        check(irq_o == 1'b1, "R8 other read keeps irq", int'(irq_o), 1);
        repeat (5) @(negedge clk);
        check(irq_o == 1'b1, "R8 irq level holds", int'(irq_o), 1);

        // R2: write clears a pending interrupt and restarts with field 1
        bus_write('h228, 32'd1, c);
        check(irq_o == 1'b0, "R2 write clears pending irq", int'(irq_o), 0);
        exp_q.push_back(c + 1 + 2 * D);
        wait_irq();
        ack();

        // R6: acknowledge colliding with an expiry, field 0
        bus_write('h228, 32'd0, c);
        x = c + 1 + D;
        exp_q.push_back(x);
        wait_irq();
        repeat (D - 1) @(negedge clk);
        bus_read('h230, "R5 count reads zero");
        check(irq_o == 1'b1, "R6 expiry wins over ack", int'(irq_o), 1);
        bus_read('h230, "R5 count reads zero");
        check(irq_o == 1'b0, "R5 later ack clears", int'(irq_o), 0);
        exp_q.push_back(x + 2 * D);
        wait_irq();

        // R3: largest field, 512 ms
        bus_write('h228, 32'd511, c);
        exp_q.push_back(c + 1 + 512 * D);
        wait_irq();
        ack();

        check(exp_q.size() == 0, "R4 all expected rises seen", exp_q.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", cyc, 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule